// File: doc/BRIEF.md
# Registered Bidirectional Bus Link

This block joins two eight-bit buses, A and B, through a pair of holding registers, one per direction. The A-to-B register takes the A bus value on each rising edge of its own clock, and the B-to-A register takes the B bus value on each rising edge of a second, independent clock. For each direction, a select line chooses what the driven bus sees: either live data passed straight across from the opposite bus, or the value held in that direction's register.

An active-low enable and a direction line decide which bus is driven, if either is. Each bus is modelled as an input vector, an output vector and an output-enable bit, so no internal tristate is needed; a pad ring or bus fabric outside the block merges them. The registers keep capturing while both outputs are disabled. This lets the block sample both buses without driving either, and later place the stored values on a bus.

The output path is purely combinational. A change on a select, enable, direction or live input shows up on the outputs in the same cycle. Reset is asynchronous and active low. Its release is synchronised separately into each register's clock domain.

Top module: `bus_link_xcvr`

## Requirements
- R1: While `rst_n` is low, both holding registers read zero at once, with no clock edge needed.
- R2: Once the A-to-B domain is out of reset, every rising edge of `clk_ab` loads `a_in` into the A-to-B register.
- R3: Once the B-to-A domain is out of reset, every rising edge of `clk_ba` loads `b_in` into the B-to-A register.
- R4: An edge of one register clock leaves the other direction's register unchanged.
- R5: With `b_oe` high and `sel_ab` low (0 = live), `b_out` equals `a_in` in the same cycle.
- R6: With `b_oe` high and `sel_ab` high (1 = stored), `b_out` equals the A-to-B register contents.
- R7: With `a_oe` high, `a_out` equals `b_in` when `sel_ba` is 0 and equals the B-to-A register when `sel_ba` is 1.
- R8: With `oe_n` low, `dir` = 1 drives bus B only (`b_oe`=1, `a_oe`=0), and `dir` = 0 drives bus A only (`a_oe`=1, `b_oe`=0). The two enables are never high together.
- R9: With `oe_n` high, both `a_oe` and `b_oe` are 0, and any undriven output vector reads all zeros.
- R10: Edges on the register clocks still capture bus data while `oe_n` is high.
- R11: After `rst_n` rises, the first two rising edges of a register's own clock leave it at zero, and the third edge captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive bus B, 0: drive bus A |
| sel_ab | input | 1 | A-to-B source: 0 live A, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live B, 1 stored |
| a_in | input | 8 | Value present on bus A |
| b_in | input | 8 | Value present on bus B |
| a_out | output | 8 | Value to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | 8 | Value to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
On every evaluation, the embedded assertions check that the two drive enables are exclusive and silent when disabled. They also check that each driven output follows either its live input or its register according to the select, and that each register holds the bus value that was present at the previous edge of its own clock. Only the bench's scenarios show the two skipped edges after reset release, the asynchronous clear, the independence of the two clock domains, and capture while both buses are released, because each of these depends on a particular order of clocks and control changes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned LINK_W   = 8;
  localparam int unsigned NUM_DOM  = 2;
  localparam int unsigned SYNC_LEN = 2;

  // Domain indices: which register serves which direction
  localparam int unsigned DOM_AB = 0;
  localparam int unsigned DOM_BA = 1;

  // Direction encoding on the dir pin
  localparam logic DIR_DRIVE_B = 1'b1;
  localparam logic DIR_DRIVE_A = 1'b0;

  // Select encoding
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_ok = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ok,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  // R2 / R3: the held value is the bus value seen at the previous edge
  a_r2_r3_capture: assert property (@(posedge clk) disable iff (!rst_ok)
    rst_ok |=> (q == $past(d)))
    else $error("hold register missed its capture");
endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel #(
  parameter int unsigned W = 8
) (
  input  xcvr_pkg::src_sel_e sel,
  input  logic [W-1:0]       live,
  input  logic [W-1:0]       stored,
  input  logic               drive,
  output logic [W-1:0]       bus_out
);
  import xcvr_pkg::*;
  logic [W-1:0] picked;

  always_comb begin
    picked = (sel == SRC_STORED) ? stored : live;
    bus_out = drive ? picked : '0;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl (
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);
  import xcvr_pkg::*;

  always_comb begin
    a_oe = 1'b0;
    b_oe = 1'b0;
    if (!oe_n) begin
      if (dir == DIR_DRIVE_B) b_oe = 1'b1;
      else                    a_oe = 1'b1;
    end
  end
endmodule

// File: rtl/bus_link_xcvr.sv
module bus_link_xcvr #(
  parameter int unsigned W = xcvr_pkg::LINK_W
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  import xcvr_pkg::*;
  localparam int unsigned ND = NUM_DOM;

  logic [ND-1:0] dom_clk;
  logic [ND-1:0] dom_rst_ok;
  logic [W-1:0]  cap_d [ND];
  logic [W-1:0]  cap_q [ND];

  assign dom_clk[DOM_AB] = clk_ab;
  assign dom_clk[DOM_BA] = clk_ba;
  assign cap_d[DOM_AB]   = a_in;
  assign cap_d[DOM_BA]   = b_in;

  for (genvar g = 0; g < ND; g++) begin : g_dom
    xcvr_rst_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk   (dom_clk[g]),
      .rst_n (rst_n),
      .rst_ok(dom_rst_ok[g])
    );
    xcvr_hold_reg #(.W(W)) u_reg (
      .clk   (dom_clk[g]),
      .rst_ok(dom_rst_ok[g]),
      .d     (cap_d[g]),
      .q     (cap_q[g])
    );
  end

  xcvr_drive_ctl u_drv (
    .oe_n(oe_n),
    .dir (dir),
    .a_oe(a_oe),
    .b_oe(b_oe)
  );

  xcvr_path_sel #(.W(W)) u_to_b (
    .sel    (src_sel_e'(sel_ab)),
    .live   (a_in),
    .stored (cap_q[DOM_AB]),
    .drive  (b_oe),
    .bus_out(b_out)
  );

  xcvr_path_sel #(.W(W)) u_to_a (
    .sel    (src_sel_e'(sel_ba)),
    .live   (b_in),
    .stored (cap_q[DOM_BA]),
    .drive  (a_oe),
    .bus_out(a_out)
  );

  always_comb begin
    // R8: one bus at most
    a_r8_single_bus: assert (!(a_oe && b_oe))
      else $error("both buses driven");
    // R9: disabled means silent
    if (oe_n) begin
      a_r9_quiet: assert (!a_oe && !b_oe && a_out == '0 && b_out == '0)
        else $error("output active while disabled");
    end
    // R5: live path toward B
    if (b_oe && !sel_ab) begin
      a_r5_live_to_b: assert (b_out == a_in)
        else $error("b_out not live A");
    end
    // R6: stored path toward B
    if (b_oe && sel_ab) begin
      a_r6_stored_to_b: assert (b_out == cap_q[DOM_AB])
        else $error("b_out not stored A-to-B value");
    end
    // R7: both sources toward A
    if (a_oe) begin
      a_r7_path_to_a: assert (a_out == (sel_ba ? cap_q[DOM_BA] : b_in))
        else $error("a_out source wrong");
    end
  end
endmodule

// File: tb/bus_link_xcvr_bench.sv
module bus_link_xcvr_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic       oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe;

  int checks = 0;
  int errors = 0;

  bus_link_xcvr u_bus_link_xcvr (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  typedef struct packed {
    logic       oe_n, dir, sel_ab, sel_ba;
    logic [7:0] a_in, b_in;
    logic       aoe, boe;
    logic [7:0] aout, bout;
  } vec_t;

  // Registers preloaded with A-to-B = 3C, B-to-A = C3 before the walk
  localparam vec_t VEC [8] = '{
    '{1'b0,1'b1,1'b0,1'b0, 8'h11,8'h22, 1'b0,1'b1, 8'h00,8'h11}, // R5 R8
    '{1'b0,1'b1,1'b1,1'b0, 8'h11,8'h22, 1'b0,1'b1, 8'h00,8'h3C}, // R6
    '{1'b0,1'b0,1'b0,1'b0, 8'h11,8'h22, 1'b1,1'b0, 8'h22,8'h00}, // R7 R8
    '{1'b0,1'b0,1'b0,1'b1, 8'h11,8'h22, 1'b1,1'b0, 8'hC3,8'h00}, // R7
    '{1'b1,1'b1,1'b1,1'b1, 8'h55,8'hAA, 1'b0,1'b0, 8'h00,8'h00}, // R9
    '{1'b1,1'b0,1'b0,1'b0, 8'h55,8'hAA, 1'b0,1'b0, 8'h00,8'h00}, // R9
    '{1'b0,1'b1,1'b0,1'b1, 8'hFF,8'h00, 1'b0,1'b1, 8'h00,8'hFF}, // R5
    '{1'b0,1'b0,1'b1,1'b0, 8'h00,8'hA5, 1'b1,1'b0, 8'hA5,8'h00}  // R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_ab();
    #2 clk_ab = 1'b1; #3 clk_ab = 1'b0; #2;
  endtask
  task automatic pulse_ba();
    #2 clk_ba = 1'b1; #3 clk_ba = 1'b0; #2;
  endtask

  // Read both registers through the stored paths
  task automatic peek(output logic [7:0] ab, output logic [7:0] ba);
    oe_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    dir = 1'b1; #1 ab = b_out;
    dir = 1'b0; #1 ba = a_out;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ab, ba;
    repeat (2) @(negedge clk);
    // R1: reset state
    peek(ab, ba);
    check("R1 reset A-to-B reg", ab, 8'h00);
    check("R1 reset B-to-A reg", ba, 8'h00);

    // R11 then R2: two ignored edges, third captures
    rst_n = 1'b1; a_in = 8'h77; b_in = 8'h66;
    pulse_ab(); pulse_ab();
    peek(ab, ba);
    check("R11 A-to-B after two edges", ab, 8'h00);
    pulse_ab();
    peek(ab, ba);
    check("R2 A-to-B capture", ab, 8'h77);
    check("R4 B-to-A untouched by clk_ab", ba, 8'h00);

    pulse_ba(); pulse_ba();
    peek(ab, ba);
    check("R11 B-to-A after two edges", ba, 8'h00);
    pulse_ba();
    peek(ab, ba);
    check("R3 B-to-A capture", ba, 8'h66);

    // R4: new A value, only clk_ba toggles
    a_in = 8'h99; b_in = 8'h44;
    pulse_ba();
    peek(ab, ba);
    check("R4 A-to-B untouched by clk_ba", ab, 8'h77);
    check("R3 B-to-A second capture", ba, 8'h44);

    // R10: capture while outputs disabled
    oe_n = 1'b1; a_in = 8'h3C; b_in = 8'hC3;
    pulse_ab(); pulse_ba();
    #1;
    check("R9 a_oe off during capture", a_oe, 1'b0);
    check("R9 b_oe off during capture", b_oe, 1'b0);
    peek(ab, ba);
    check("R10 A-to-B captured while disabled", ab, 8'h3C);
    check("R10 B-to-A captured while disabled", ba, 8'hC3);

    // Vector walk
    foreach (VEC[i]) begin
      oe_n = VEC[i].oe_n; dir = VEC[i].dir;
      sel_ab = VEC[i].sel_ab; sel_ba = VEC[i].sel_ba;
      a_in = VEC[i].a_in; b_in = VEC[i].b_in;
      #1;
      check($sformatf("R8 vec%0d a_oe", i), a_oe, VEC[i].aoe);
      check($sformatf("R8 vec%0d b_oe", i), b_oe, VEC[i].boe);
      check($sformatf("R7 R9 vec%0d a_out", i), a_out, VEC[i].aout);
      check($sformatf("R5 R6 R9 vec%0d b_out", i), b_out, VEC[i].bout);
    end

    // R1: asynchronous clear, no clock edge
    rst_n = 1'b0;
    peek(ab, ba);
    check("R1 async clear A-to-B", ab, 8'h00);
    check("R1 async clear B-to-A", ba, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule